// File: doc/BRIEF.md
# Differential Trace Timestamp Generator

This block keeps a running delta-time count for a trace unit and asks for a timestamp whenever that count should be reported. A timestamp enable starts a prescaler and a saturating counter. The prescaler divides by 1, 4, 16 or 64. The block raises a request that carries the current count and a cause code in three cases: when the trace FIFO signals that a packet was written while the count is non-zero, when the counter saturates, or when a fixed number of cycles pass with no packet. Once a request is taken the counter restarts from zero, so each reported value is the time since the previous report. The request stays up until the consumer acknowledges it.

A line-activity mode lets the count advance only while the trace output line is busy. While the line is idle the counter and the prescaler are held at zero, and no idle-interval reports are made. Clearing the enable clears all internal state and withdraws any request.

Top module: `trace_delta_stamp`

## Requirements
- R1: After a synchronous reset, `stamp_req` is 0, `stamp_val` is 0 and `stamp_cause` is 0.
- R2: With counting active, the counter advances by one every 1, 4, 16 or 64 active cycles, for `prescale_sel` values 0, 1, 2 and 3 respectively.
- R3: A `pkt_wr` pulse while the count is non-zero raises a request on the next cycle. The request carries the count from the cycle of the pulse and cause code 1. A pulse while the count is zero raises nothing.
- R4: In the cycle a request is taken, the counter and the prescaler restart from zero.
- R5: The counter saturates at its all-ones value. A saturated count raises a request with cause code 2.
- R6: With `line_mode` = 0, the IDLE_CYCLES-th consecutive enabled cycle without `pkt_wr` raises a request with cause code 3, even if the count is zero.
- R7: With `line_mode` = 1, the counter and the prescaler are held at zero while `line_active` = 0, and no cause-3 request is raised.
- R8: While `ts_en` = 0, the counter, the prescaler and the idle timer are cleared, and from the next cycle `stamp_req` and `stamp_val` are 0 whatever `line_mode` is.
- R9: A raised request keeps `stamp_req`, `stamp_val` and `stamp_cause` unchanged until a cycle with `req_ack` = 1. If a new trigger falls in that acknowledge cycle, the new request replaces the old one. A trigger that falls while a request is pending and not acknowledged is dropped.
- R10: When a saturated count and a packet write fall in the same cycle, the request carries cause code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_en | input | 1 | Timestamp enable |
| prescale_sel | input | 2 | Divide select: 0 = /1, 1 = /4, 2 = /16, 3 = /64 |
| line_mode | input | 1 | 1 = count only while the output line is active |
| line_active | input | 1 | Trace output line busy |
| pkt_wr | input | 1 | Packet written into the trace FIFO |
| req_ack | input | 1 | Consumer takes the pending request |
| stamp_req | output | 1 | Timestamp request pending |
| stamp_val | output | CNT_W | Delta count carried by the request |
| stamp_cause | output | 2 | 0 none, 1 packet, 2 overflow, 3 idle interval |

## Verification
The case that needs most care is an acknowledge and a fresh trigger landing in the same cycle. The new request must replace the old one rather than be lost. The bench provokes this by acknowledging at random and writing packets at random. It compares every cycle against a reference model written from the requirements. A second coincidence is a packet write in the cycle the counter sits saturated. The bench aims it on purpose by writing a packet exactly when its model holds the maximum count, and expects cause code 2.

// File: rtl/ts_pkg.sv
`timescale 1ns/1ps
package ts_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_PKT  = 2'd1,
    CAUSE_OVF  = 2'd2,
    CAUSE_IDLE = 2'd3
  } cause_t;
endpackage

// File: rtl/ts_prescaler.sv
`timescale 1ns/1ps
module ts_prescaler #(
  parameter int SEL_W = 2,
  localparam int PRE_W = 2 * ((1 << SEL_W) - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;

  // divide by 4**sel: limit = 4**sel - 1
  assign limit = ~({PRE_W{1'b1}} << (2 * sel));
  assign tick  = run & (pre_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr)
      pre_q <= '0;
    else if (tick)
      pre_q <= '0;
    else
      pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/ts_delta_counter.sv
`timescale 1ns/1ps
module ts_delta_counter #(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             at_max
);
  assign at_max = (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc && !at_max)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ts_idle_timer.sv
`timescale 1ns/1ps
module ts_idle_timer #(
  parameter int IDLE_CYCLES = 2_000_000,
  localparam int IDLE_W = $clog2(IDLE_CYCLES)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic fire
);
  logic [IDLE_W-1:0] idle_q;

  assign fire = !clr && (idle_q == IDLE_W'(IDLE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst || clr || fire)
      idle_q <= '0;
    else
      idle_q <= idle_q + 1'b1;
  end
endmodule

// File: rtl/ts_emitter.sv
`timescale 1ns/1ps
module ts_emitter
  import ts_pkg::*;
#(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             take,
  input  cause_t           cause,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ack,
  output logic             req,
  output logic [CNT_W-1:0] val,
  output cause_t           cause_q
);
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      req     <= 1'b0;
      val     <= '0;
      cause_q <= CAUSE_NONE;
    end else if (take) begin
      req     <= 1'b1;
      val     <= cnt;
      cause_q <= cause;
    end else if (ack) begin
      req     <= 1'b0;
    end
  end
endmodule

// File: rtl/trace_delta_stamp.sv
`timescale 1ns/1ps
module trace_delta_stamp
  import ts_pkg::*;
#(
  parameter int CNT_W       = 21,
  parameter int IDLE_CYCLES = 2_000_000,
  parameter int SEL_W       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ts_en,
  input  logic [SEL_W-1:0] prescale_sel,
  input  logic             line_mode,
  input  logic             line_active,
  input  logic             pkt_wr,
  input  logic             req_ack,
  output logic             stamp_req,
  output logic [CNT_W-1:0] stamp_val,
  output logic [1:0]       stamp_cause
);
  logic             active, tick, at_max, cnt_clr, idle_clr, idle_fire;
  logic             free, trig_pkt, trig_ovf, trig_idle, emit;
  logic [CNT_W-1:0] cnt_q;
  cause_t           cause_sel, cause_q;

  assign active    = ts_en & (~line_mode | line_active);
  assign free      = ~stamp_req | req_ack;
  assign trig_ovf  = ts_en & at_max;
  assign trig_pkt  = ts_en & pkt_wr & (cnt_q != '0);
  assign trig_idle = ts_en & idle_fire;
  assign emit      = free & (trig_ovf | trig_pkt | trig_idle);
  assign cnt_clr   = ~active | emit;
  assign idle_clr  = ~ts_en | line_mode | pkt_wr;

  always_comb begin
    if (trig_ovf)      cause_sel = CAUSE_OVF;
    else if (trig_pkt) cause_sel = CAUSE_PKT;
    else               cause_sel = CAUSE_IDLE;
  end

  ts_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .clr(cnt_clr), .run(active),
    .sel(prescale_sel), .tick(tick)
  );

  ts_delta_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(tick),
    .cnt(cnt_q), .at_max(at_max)
  );

  ts_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk(clk), .rst(rst), .clr(idle_clr), .fire(idle_fire)
  );

  ts_emitter #(.CNT_W(CNT_W)) u_emit (
    .clk(clk), .rst(rst), .en(ts_en), .take(emit), .cause(cause_sel),
    .cnt(cnt_q), .ack(req_ack), .req(stamp_req), .val(stamp_val),
    .cause_q(cause_q)
  );

  assign stamp_cause = cause_q;
endmodule

module trace_delta_stamp_chk #(
  parameter int CNT_W = 21
) (
  input logic             clk,
  input logic             rst,
  input logic             ts_en,
  input logic             line_mode,
  input logic             line_active,
  input logic             req_ack,
  input logic             stamp_req,
  input logic [CNT_W-1:0] stamp_val,
  input logic [1:0]       stamp_cause,
  input logic [CNT_W-1:0] cnt_q,
  input logic             at_max,
  input logic             active,
  input logic             emit,
  input logic             free
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ts_en && stamp_req && !req_ack |=> stamp_req && $stable(stamp_val) && $stable(stamp_cause));
  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ts_en |=> !stamp_req && (stamp_val == '0));
  // R4
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    emit |=> (cnt_q == '0));
  // R7
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ts_en && line_mode && !line_active |=> (cnt_q == '0));
  // R5
  saturate_chk: assert property (@(posedge clk) disable iff (rst)
    ts_en && at_max && active && !emit |=> at_max);
  // R10
  overflow_req_chk: assert property (@(posedge clk) disable iff (rst)
    ts_en && at_max && free |=> stamp_req && (stamp_cause == 2'd2));
  // R3
  pkt_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stamp_req) && (stamp_cause == 2'd1) |-> (stamp_val != '0));
  // R6
  idle_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stamp_req) && (stamp_cause == 2'd3) |-> $past(!line_mode));
endmodule

bind trace_delta_stamp trace_delta_stamp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ts_en(ts_en), .line_mode(line_mode),
  .line_active(line_active), .req_ack(req_ack), .stamp_req(stamp_req),
  .stamp_val(stamp_val), .stamp_cause(stamp_cause), .cnt_q(cnt_q),
  .at_max(at_max), .active(active), .emit(emit), .free(free)
);

// File: tb/test_trace_delta_stamp.sv
`timescale 1ns/1ps
module test_trace_delta_stamp;
  localparam int CNT_W = 6;
  localparam int IDLE  = 40;
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ts_en = 1'b0, line_mode = 1'b0, line_active = 1'b0;
  logic pkt_wr = 1'b0, req_ack = 1'b0;
  logic [1:0] prescale_sel = 2'd0;
  logic stamp_req;
  logic [CNT_W-1:0] stamp_val;
  logic [1:0] stamp_cause;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference state
  int m_pre = 0, m_idle = 0;
  logic [CNT_W-1:0] m_cnt = '0, m_val = '0;
  logic m_req = 1'b0;
  logic [1:0] m_cause = 2'd0;

  always #4 clk = ~clk;

  trace_delta_stamp #(.CNT_W(CNT_W), .IDLE_CYCLES(IDLE)) i_trace_delta_stamp (
    .clk(clk), .rst(rst), .ts_en(ts_en), .prescale_sel(prescale_sel),
    .line_mode(line_mode), .line_active(line_active), .pkt_wr(pkt_wr),
    .req_ack(req_ack), .stamp_req(stamp_req), .stamp_val(stamp_val),
    .stamp_cause(stamp_cause)
  );

  function automatic int div_of(logic [1:0] s);
    return 1 << (2 * s);
  endfunction

  always @(posedge clk) begin
    bit act, free, ovf, pk, idl;
    if (rst || !ts_en) begin
      m_pre = 0; m_idle = 0; m_cnt = '0; m_req = 1'b0; m_val = '0; m_cause = 2'd0;
    end else begin
      act  = !line_mode || line_active;
      free = !m_req || req_ack;
      ovf  = (m_cnt == MAXV);
      pk   = pkt_wr && (m_cnt != '0);
      idl  = !line_mode && !pkt_wr && (m_idle == IDLE - 1);
      if (line_mode || pkt_wr || idl) m_idle = 0; else m_idle = m_idle + 1;
      if (free && (ovf || pk || idl)) begin
        m_req = 1'b1; m_val = m_cnt;
        m_cause = ovf ? 2'd2 : (pk ? 2'd1 : 2'd3);
        m_cnt = '0; m_pre = 0;
      end else begin
        if (req_ack) m_req = 1'b0;
        if (!act) begin
          m_cnt = '0; m_pre = 0;
        end else if (m_pre >= div_of(prescale_sel) - 1) begin
          m_pre = 0;
          if (m_cnt != MAXV) m_cnt = m_cnt + 1'b1;
        end else begin
          m_pre = m_pre + 1;
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic cyc(string tag);
    @(negedge clk);
    checks++;
    if ({stamp_req, stamp_val, stamp_cause} !== {m_req, m_val, m_cause}) begin
      fails++;
      $display("FAIL %s: actual req=%0b val=%0d cause=%0d expected req=%0b val=%0d cause=%0d",
               tag, stamp_req, stamp_val, stamp_cause, m_req, m_val, m_cause);
    end
  endtask

  initial begin
    void'($urandom(32'd77341));
    // R1 reset state
    cyc("R1"); cyc("R1");
    rst = 1'b0;
    cyc("R1");
    // R8 disabled: line mode and packets have no effect
    for (int i = 0; i < 60; i++) begin
      line_mode = 1'($urandom); line_active = 1'($urandom);
      pkt_wr = 1'($urandom); req_ack = 1'($urandom);
      cyc("R8");
    end
    // R2 each prescale setting, line mode with busy line (no idle stamps)
    ts_en = 1'b1; line_mode = 1'b1; line_active = 1'b1; req_ack = 1'b1;
    for (int s = 0; s < 4; s++) begin
      prescale_sel = 2'(s);
      for (int i = 0; i < 5 * (5 * div_of(2'(s)) + 3); i++) begin
        pkt_wr = ((i % (5 * div_of(2'(s)) + 3)) == 0);
        cyc("R2");
      end
    end
    // R3 and R4: back-to-back packets; the second sees a zero count
    prescale_sel = 2'd0;
    for (int i = 0; i < 120; i++) begin
      pkt_wr = ((i % 10) < 2);
      cyc((i % 10) == 2 ? "R4" : "R3");
    end
    // R5 saturation and overflow, with slow acknowledge
    pkt_wr = 1'b0;
    for (int i = 0; i < 300; i++) begin
      req_ack = ((i % 50) == 49);
      cyc("R5");
    end
    // R10 packet aimed at the saturated cycle
    req_ack = 1'b1;
    for (int i = 0; i < 300; i++) begin
      pkt_wr = (m_cnt == MAXV);
      cyc("R10");
    end
    // R6 idle interval in normal mode
    line_mode = 1'b0; pkt_wr = 1'b0; prescale_sel = 2'd3;
    for (int i = 0; i < 200; i++) cyc("R6");
    // R7 line mode with a toggling line
    line_mode = 1'b1; prescale_sel = 2'd1;
    for (int i = 0; i < 400; i++) begin
      line_active = ($urandom % 4) != 0;
      pkt_wr = ($urandom % 6) == 0;
      cyc("R7");
    end
    // R9 random handshake with coinciding acknowledge and triggers
    for (int i = 0; i < 3000; i++) begin
      ts_en = ($urandom % 64) != 0;
      line_mode = ($urandom % 200) == 0 ? ~line_mode : line_mode;
      line_active = ($urandom % 3) != 0;
      prescale_sel = ($urandom % 100) == 0 ? 2'($urandom) : prescale_sel;
      pkt_wr = ($urandom % 8) == 0;
      req_ack = ($urandom % 4) == 0;
      cyc("R9");
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog: actual still running expected completion");
      summary();
      $finish;
    end
  end
endmodule